// File: doc/BRIEF.md
# Two-Level Systolic Multiply-Accumulate Mesh

This block is a small matrix-multiply array of signed 8-bit multiply-accumulate cells. The cells are grouped into tiles. Inside a tile, operands and partial sums ripple through the cells with no register. Between tiles they pass through one pipeline register. The parameters `TR`/`TC` set the cells per tile and `MR`/`MC` set the tiles per mesh. With these, one code base covers everything from a single wide combinational tile to a fully registered systolic grid. Each cell does one multiply-accumulate per clock, and data only moves to the nearest neighbour to the east or the south.

A per-run select input chooses between two dataflows.

- **Weight-stationary:** one weight per cell is loaded first by a shifting preload. Row operand vectors then stream east, and column sums leave the bottom edge.
- **Output-stationary:** row operands flow east and column operands flow south. Every cell keeps its own running sum, and a drain command later shifts these sums out one column at a time.

The caller presents plain, un-skewed vectors with a valid bit. The mesh creates the skew internally and removes it again from the column results. The select must stay steady while any data is in flight.

Top module: `sys_mesh`

## Requirements
- R1: While reset is high at a clock edge, `col_vld` and `row_vld` are cleared, and so are every cell's stationary weight and running sum.
- R2: Each clock edge with `preload` high does two things. It moves every stored weight down one row, and it loads row 0, column j with lane j of `col_b` (signed 8-bit at bits 8j+7..8j). After R strobes, the first vector loaded sits in the bottom row.
- R3: In weight-stationary mode (`os_sel` low), an accepted vector produces lane j of `col_res` (signed, AW bits at AW*j). That lane equals lane j of `col_b`, used as a bias, plus the sum over rows i of `row_a` lane i times weight(i,j).
- R4: A weight-stationary vector sampled at one edge shows up with `col_vld` high after exactly MR+MC-1 edges, counting the sampling edge. All lanes show up together.
- R5: A new weight-stationary vector is accepted on every cycle. A cycle with `in_vld` low produces a cycle with `col_vld` low at the same result position.
- R6: Every running sum saturates after each cell's step to the range -2^(AW-1) .. 2^(AW-1)-1. The weight-stationary column sum is built starting at the top row.
- R7: In output-stationary mode (`os_sel` high), cell (i,j) adds `row_a` lane i times `col_b` lane j on each valid cycle, in the order the cycles arrive. Cycles with `in_vld` low change nothing, and `col_vld` stays low.
- R8: Each edge with `drain` high does three things. It moves every running sum one column east, it puts zero into column 0, and it latches column C-1 of row i into lane i of `row_res`. C consecutive drains therefore give columns C-1 down to 0 and leave all sums at zero.
- R9: `row_vld` is high after an edge exactly when `drain` was high at that edge.
- R10: Stationary weights change only on preload. They survive weight-stationary streaming and whole output-stationary runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_sel | input | 1 | 1 selects output-stationary, 0 selects weight-stationary |
| in_vld | input | 1 | Qualifies `row_a`/`col_b` as compute data |
| row_a | input | 8*TR*MR | Row operand lanes, signed 8-bit each |
| col_b | input | 8*TC*MC | Column lanes: weights on preload, bias in weight-stationary, operands in output-stationary |
| preload | input | 1 | Shifts a weight row into the mesh |
| drain | input | 1 | Shifts running sums out east by one column |
| col_res | output | AW*TC*MC | Weight-stationary column results |
| col_vld | output | 1 | Marks `col_res` as valid |
| row_res | output | AW*TR*MR | Drained running sums, one lane per row |
| row_vld | output | 1 | Marks `row_res` as valid |

## Verification
Column results are due MR+MC-1 edges after their vector is sampled, which is 3 with the default tiles. Drained sums are due on the first edge after the drain. The bench keeps a reference pipeline exactly that deep, filled at each rising edge from the sampled inputs. It drives inputs and compares every output on the falling edge, so each expected value lines up with the edge on which the design must present it. Output-stationary sums are updated in the model as each cycle is sampled. Every drain is preceded by idle cycles that flush the in-flight skew, so the exact arrival cycle inside the mesh does not affect the comparison.

// File: rtl/sys_mesh.sv
`timescale 1ns/1ps
module sys_mesh #(
  parameter int TR = 2,
  parameter int TC = 2,
  parameter int MR = 2,
  parameter int MC = 2,
  parameter int AW = 20,
  localparam int R = TR * MR,
  localparam int C = TC * MC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            os_sel,
  input  logic            in_vld,
  input  logic [R*8-1:0]  row_a,
  input  logic [C*8-1:0]  col_b,
  input  logic            preload,
  input  logic            drain,
  output logic [C*AW-1:0] col_res,
  output logic            col_vld,
  output logic [R*AW-1:0] row_res,
  output logic            row_vld
);
  localparam int LAT = MR + MC - 1;
  localparam int SW = (AW > 16 ? AW : 16) + 1;
  localparam logic signed [SW-1:0] PMAX = SW'((2 ** (AW - 1)) - 1);
  localparam logic signed [SW-1:0] PMIN = ~PMAX;

  function automatic logic signed [AW-1:0] sadd(input logic signed [AW-1:0] p,
                                                input logic signed [15:0] q);
    logic signed [SW-1:0] s;
    s = SW'(p) + SW'(q);
    if (s > PMAX) return PMAX[AW-1:0];
    if (s < PMIN) return PMIN[AW-1:0];
    return s[AW-1:0];
  endfunction

  logic signed [7:0]    a_w [R][C];
  logic signed [7:0]    b_w [R][C];
  logic signed [7:0]    wgt [R][C];
  logic                 v_w [R][C];
  logic signed [AW-1:0] p_w [R][C];
  logic signed [AW-1:0] p_o [R][C];
  logic signed [AW-1:0] acc [R][C];
  logic signed [7:0]    cs  [C];
  logic [LAT-1:0]       vp;

  for (genvar i = 0; i < R; i++) begin : g_rskew
    localparam int D = i / TR;
    if (D == 0) begin : g_now
      assign a_w[i][0] = row_a[i*8 +: 8];
      assign v_w[i][0] = in_vld;
    end else begin : g_dly
      logic [8:0] sr [D];
      always_ff @(posedge clk) begin
        if (rst) for (int k = 0; k < D; k++) sr[k] <= '0;
        else begin
          sr[0] <= {in_vld, row_a[i*8 +: 8]};
          for (int k = 1; k < D; k++) sr[k] <= sr[k-1];
        end
      end
      assign {v_w[i][0], a_w[i][0]} = sr[D-1];
    end
  end

  for (genvar j = 0; j < C; j++) begin : g_cskew
    localparam int D = j / TC;
    if (D == 0) begin : g_now
      assign cs[j] = col_b[j*8 +: 8];
    end else begin : g_dly
      logic [7:0] sr [D];
      always_ff @(posedge clk) begin
        sr[0] <= col_b[j*8 +: 8];
        for (int k = 1; k < D; k++) sr[k] <= sr[k-1];
      end
      assign cs[j] = sr[D-1];
    end
    assign b_w[0][j] = cs[j];
    assign p_w[0][j] = AW'(cs[j]);
  end

  for (genvar i = 0; i < R; i++) begin : g_east
    for (genvar j = 0; j + 1 < C; j++) begin : g_col
      if ((j + 1) % TC == 0) begin : g_reg
        logic signed [7:0] ar;
        logic vr;
        always_ff @(posedge clk) begin
          ar <= a_w[i][j];
          vr <= rst ? 1'b0 : v_w[i][j];
        end
        assign a_w[i][j+1] = ar;
        assign v_w[i][j+1] = vr;
      end else begin : g_wire
        assign a_w[i][j+1] = a_w[i][j];
        assign v_w[i][j+1] = v_w[i][j];
      end
    end
  end

  for (genvar i = 0; i + 1 < R; i++) begin : g_south
    for (genvar j = 0; j < C; j++) begin : g_col
      if ((i + 1) % TR == 0) begin : g_reg
        logic signed [7:0] br;
        logic signed [AW-1:0] pr;
        always_ff @(posedge clk) begin
          br <= b_w[i][j];
          pr <= p_o[i][j];
        end
        assign b_w[i+1][j] = br;
        assign p_w[i+1][j] = pr;
      end else begin : g_wire
        assign b_w[i+1][j] = b_w[i][j];
        assign p_w[i+1][j] = p_o[i][j];
      end
    end
  end

  for (genvar i = 0; i < R; i++) begin : g_pe_r
    for (genvar j = 0; j < C; j++) begin : g_pe
      logic signed [7:0] wq, m, w_up;
      logic signed [15:0] pr;
      logic signed [AW-1:0] acc_q, acc_in;
      if (i == 0) begin : g_wtop
        assign w_up = col_b[j*8 +: 8];
      end else begin : g_wmid
        assign w_up = wgt[i-1][j];
      end
      if (j == 0) begin : g_aw
        assign acc_in = '0;
      end else begin : g_am
        assign acc_in = acc[i][j-1];
      end
      assign m = os_sel ? b_w[i][j] : wq;
      assign pr = 16'(a_w[i][j]) * 16'(m);
      assign p_o[i][j] = sadd(p_w[i][j], pr);
      assign wgt[i][j] = wq;
      assign acc[i][j] = acc_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          wq <= '0;
          acc_q <= '0;
        end else begin
          if (preload) wq <= w_up;
          if (drain) acc_q <= acc_in;
          else if (os_sel && v_w[i][j]) acc_q <= sadd(acc_q, pr);
        end
      end
    end
  end

  for (genvar j = 0; j < C; j++) begin : g_out
    localparam int E = MC - 1 - j / TC;
    logic signed [AW-1:0] dq, rq;
    if (E == 0) begin : g_now
      assign dq = p_o[R-1][j];
    end else begin : g_dly
      logic signed [AW-1:0] sr [E];
      always_ff @(posedge clk) begin
        sr[0] <= p_o[R-1][j];
        for (int k = 1; k < E; k++) sr[k] <= sr[k-1];
      end
      assign dq = sr[E-1];
    end
    always_ff @(posedge clk) rq <= dq;
    assign col_res[j*AW +: AW] = rq;
  end

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else vp <= LAT'({vp, in_vld & ~os_sel});
  end
  assign col_vld = vp[LAT-1];

  for (genvar i = 0; i < R; i++) begin : g_drn
    logic signed [AW-1:0] rr;
    always_ff @(posedge clk) if (drain) rr <= acc[i][C-1];
    assign row_res[i*AW +: AW] = rr;
  end

  always_ff @(posedge clk) row_vld <= rst ? 1'b0 : drain;
endmodule

// File: rtl/mesh_chk.sv
`timescale 1ns/1ps
module mesh_chk #(
  parameter int LAT = 3
) (
  input logic clk,
  input logic rst,
  input logic os_sel,
  input logic in_vld,
  input logic drain,
  input logic col_vld,
  input logic row_vld
);
  int pend;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) pend <= 0;
    else pend <= pend + int'(in_vld && !os_sel) - int'(col_vld);
  end

  // R1
  always @(posedge clk) if (rst_q) rst_clear_chk: assert (!col_vld && !row_vld);

  // R9
  drain_vld_chk: assert property (@(posedge clk) disable iff (rst) drain |=> row_vld);

  // R9
  row_src_chk: assert property (@(posedge clk) disable iff (rst) row_vld |-> $past(drain));

  // R4
  col_src_chk: assert property (@(posedge clk) disable iff (rst) col_vld |-> pend > 0);

  // R5
  inflight_chk: assert property (@(posedge clk) disable iff (rst) pend <= LAT);
endmodule

bind sys_mesh mesh_chk #(.LAT(MR + MC - 1)) u_chk (
  .clk(clk), .rst(rst), .os_sel(os_sel), .in_vld(in_vld),
  .drain(drain), .col_vld(col_vld), .row_vld(row_vld)
);

// File: tb/tb_sys_mesh.sv
`timescale 1ns/1ps
module tb_sys_mesh;
  localparam int TR = 2, TC = 2, MR = 2, MC = 2, AW = 16;
  localparam int R = TR * MR, C = TC * MC, LAT = MR + MC - 1;
  localparam int HI = 2 ** (AW - 1) - 1, LO = -(2 ** (AW - 1));

  logic clk = 1'b0, rst = 1'b1, os_sel = 1'b0, in_vld = 1'b0, preload = 1'b0, drain = 1'b0;
  logic [R*8-1:0] row_a = '0;
  logic [C*8-1:0] col_b = '0;
  logic [C*AW-1:0] col_res;
  logic [R*AW-1:0] row_res;
  logic col_vld, row_vld;

  sys_mesh #(.TR(TR), .TC(TC), .MR(MR), .MC(MC), .AW(AW)) dut (
    .clk(clk), .rst(rst), .os_sel(os_sel), .in_vld(in_vld), .row_a(row_a),
    .col_b(col_b), .preload(preload), .drain(drain), .col_res(col_res),
    .col_vld(col_vld), .row_res(row_res), .row_vld(row_vld)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  int W [R][C];
  int ACC [R][C];
  int pv [LAT];
  int pd [LAT][C];
  int exp_rv = 0;
  int exp_rr [R];

  function automatic int sat(int x);
    if (x > HI) return HI;
    if (x < LO) return LO;
    return x;
  endfunction

  function automatic int sb(logic [7:0] x);
    return int'($signed(x));
  endfunction

  task automatic chk(string what, int lane, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s lane %0d got %0d expected %0d", tag, what, lane, got, exp);
    end
  endtask

  task automatic model_edge();
    int nd [C];
    int nv;
    for (int k = LAT - 1; k > 0; k--) begin
      pv[k] = pv[k-1];
      pd[k] = pd[k-1];
    end
    for (int j = 0; j < C; j++) begin
      int s;
      s = sb(col_b[j*8 +: 8]);
      for (int i = 0; i < R; i++) s = sat(s + sb(row_a[i*8 +: 8]) * W[i][j]);
      nd[j] = s;
    end
    nv = (!rst && in_vld && !os_sel) ? 1 : 0;
    pv[0] = nv;
    pd[0] = nd;
    if (rst) begin
      for (int k = 0; k < LAT; k++) pv[k] = 0;
      for (int i = 0; i < R; i++)
        for (int j = 0; j < C; j++) begin
          ACC[i][j] = 0;
          W[i][j] = 0;
        end
      exp_rv = 0;
      return;
    end
    exp_rv = drain ? 1 : 0;
    if (drain) begin
      for (int i = 0; i < R; i++) begin
        exp_rr[i] = ACC[i][C-1];
        for (int j = C - 1; j > 0; j--) ACC[i][j] = ACC[i][j-1];
        ACC[i][0] = 0;
      end
    end else if (in_vld && os_sel) begin
      for (int i = 0; i < R; i++)
        for (int j = 0; j < C; j++)
          ACC[i][j] = sat(ACC[i][j] + sb(row_a[i*8 +: 8]) * sb(col_b[j*8 +: 8]));
    end
    if (preload) begin
      for (int i = R - 1; i > 0; i--)
        for (int j = 0; j < C; j++) W[i][j] = W[i-1][j];
      for (int j = 0; j < C; j++) W[0][j] = sb(col_b[j*8 +: 8]);
    end
  endtask

  task automatic compare();
    chk("col_vld", 0, int'(col_vld), pv[LAT-1]);
    if (pv[LAT-1] != 0)
      for (int j = 0; j < C; j++)
        chk("col_res", j, int'($signed(col_res[j*AW +: AW])), pd[LAT-1][j]);
    chk("row_vld", 0, int'(row_vld), exp_rv);
    if (exp_rv != 0)
      for (int i = 0; i < R; i++)
        chk("row_res", i, int'($signed(row_res[i*AW +: AW])), exp_rr[i]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic drive(logic v, int a [R], int b [C]);
    in_vld = v;
    for (int i = 0; i < R; i++) row_a[i*8 +: 8] = 8'(a[i]);
    for (int j = 0; j < C; j++) col_b[j*8 +: 8] = 8'(b[j]);
  endtask

  function automatic int rnd8();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  task automatic send_rand(logic v);
    int a [R];
    int b [C];
    for (int i = 0; i < R; i++) a[i] = rnd8();
    for (int j = 0; j < C; j++) b[j] = rnd8();
    drive(v, a, b);
    cyc();
  endtask

  task automatic idle(int n);
    int a [R];
    int b [C];
    for (int i = 0; i < R; i++) a[i] = 0;
    for (int j = 0; j < C; j++) b[j] = 0;
    drive(1'b0, a, b);
    repeat (n) cyc();
  endtask

  task automatic load_rand_weights();
    preload = 1'b1;
    repeat (R) send_rand(1'b0);
    preload = 1'b0;
  endtask

  task automatic fill_const(int av, int bv, logic v);
    int a [R];
    int b [C];
    for (int i = 0; i < R; i++) a[i] = av;
    for (int j = 0; j < C; j++) b[j] = bv;
    drive(v, a, b);
    cyc();
  endtask

  task automatic drains(int n);
    drain = 1'b1;
    repeat (n) cyc();
    drain = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run got stuck, expected completion");
    finish_run();
  end

  initial begin
    int a [R];
    int b [C];
    for (int k = 0; k < LAT; k++) pv[k] = 0;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    tag = "R1";
    idle(2);
    drains(C);
    idle(1);

    tag = "R2";
    load_rand_weights();
    send_rand(1'b1);
    idle(LAT + 1);

    tag = "R3";
    repeat (3) begin
      send_rand(1'b1);
      idle(2);
    end
    idle(LAT);

    tag = "R4";
    send_rand(1'b1);
    idle(LAT + 2);

    tag = "R5";
    for (int n = 0; n < 8; n++) send_rand(n != 3 && n != 6);
    idle(LAT + 1);

    tag = "R6";
    preload = 1'b1;
    repeat (R) fill_const(0, 127, 1'b0);
    preload = 1'b0;
    fill_const(127, 0, 1'b1);
    fill_const(-128, 0, 1'b1);
    for (int i = 0; i < R; i++) a[i] = (i == R - 1) ? -128 : 127;
    for (int j = 0; j < C; j++) b[j] = 0;
    drive(1'b1, a, b);
    cyc();
    fill_const(-128, -128, 1'b1);
    idle(LAT + 1);

    tag = "R7";
    os_sel = 1'b1;
    idle(LAT);
    for (int n = 0; n < 7; n++) send_rand(n != 2 && n != 5);
    idle(LAT + 2);

    tag = "R8";
    drains(C);
    idle(1);
    drains(C);
    idle(1);

    tag = "R9";
    fill_const(100, 100, 1'b1);
    idle(LAT + 2);
    drains(1);
    idle(2);
    drains(C - 1);
    idle(2);

    tag = "R10";
    os_sel = 1'b0;
    idle(LAT);
    send_rand(1'b1);
    send_rand(1'b1);
    idle(LAT + 2);

    finish_run();
  end
endmodule